// File: doc/BRIEF.md
# Device Lifecycle State Controller

This block holds the lifecycle stage of a device and moves it only along a fixed set of one-way hops. Software asks for a hop by presenting a target stage together with an unlock token. The hop is taken when the token matches a configured constant and the hop is in the allowed set. Every request gets a one-cycle result code, and every accepted hop is followed by a one-cycle completion pulse.

A separate escalation strobe from the alert path drives the device straight into the scrapped stage from any stage. It needs no token and cannot be refused. The scrapped stage has no exit.

Top module: `lifecycle_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `stage_o` is 0 (RAW), `resp_valid_o` is 0 and `hop_done_o` is 0. The stage codes are RAW=0, TEST_UNLOCKED=1, DEV=2, PROD=3, RMA=4 and SCRAP=5.
- R2: A request from RAW to TEST_UNLOCKED with the correct token is accepted. `stage_o` shows the new stage one cycle after the request cycle. In that same cycle `resp_valid_o`=1 and `resp_code_o`=0 (OK).
- R3: With the correct token, the hops TEST_UNLOCKED to DEV, PROD or RMA, and DEV, PROD or RMA to SCRAP, are accepted in the same way.
- R4: Any other hop is rejected with `resp_code_o`=1 (ILLEGAL) and the stage does not change. This includes RAW to DEV, a target equal to the current stage, and the unused target codes 6 and 7.
- R5: In SCRAP every request is rejected as ILLEGAL and the stage stays 5.
- R6: A request for an allowed hop that carries a token other than `UNLOCK_TOKEN` is rejected with `resp_code_o`=2 (TOKEN_ERROR), and the stage does not change. A request that is illegal and also carries a wrong token reports ILLEGAL.
- R7: When `esc_scrap_i` is high in a cycle, `stage_o` is 5 in the next cycle, whatever the prior stage and with no token. The strobe alone produces no response and no completion pulse.
- R8: When `esc_scrap_i` and `req_valid_i` are high in the same cycle, the stage goes to SCRAP and the request is reported with `resp_code_o`=3 (PREEMPTED).
- R9: `hop_done_o` is high for exactly one cycle. That cycle is the one after the cycle in which an OK response and the new stage appear. It is never high otherwise.
- R10: `resp_valid_o` is high for exactly one cycle per request, in the cycle after the request, and is low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Software hop request strobe |
| req_target_i | input | 3 | Requested target stage code |
| req_token_i | input | TOKEN_W | Unlock token carried with the request |
| esc_scrap_i | input | 1 | Escalation strobe forcing SCRAP |
| stage_o | output | 3 | Current lifecycle stage code |
| resp_valid_o | output | 1 | Result of last cycle's request is valid |
| resp_code_o | output | 2 | 0 OK, 1 ILLEGAL, 2 TOKEN_ERROR, 3 PREEMPTED |
| hop_done_o | output | 1 | One-cycle pulse after an accepted hop |

## Verification
The escalation strobe and a software request can land in the same cycle. Escalation must win, and the request must still receive a response, coded PREEMPTED. The bench raises both inputs together from several stages, including from TEST_UNLOCKED with a request that would otherwise be legal and carries a good token. It then checks three things against its reference model: SCRAP appears on the next cycle, the response reads 3, and no completion pulse follows. A completion pulse from an earlier accepted hop can also overlap an escalation strobe. The bench covers that overlap by raising escalation in the cycle right after an accepted hop.

// File: rtl/lifecycle_ctrl.sv
module lifecycle_ctrl #(
  parameter int                 TOKEN_W      = 32,
  parameter logic [TOKEN_W-1:0] UNLOCK_TOKEN = 32'hC0DE_5AFE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [2:0]         req_target_i,
  input  logic [TOKEN_W-1:0] req_token_i,
  input  logic               esc_scrap_i,
  output logic [2:0]         stage_o,
  output logic               resp_valid_o,
  output logic [1:0]         resp_code_o,
  output logic               hop_done_o
);

  localparam logic [2:0] ST_RAW   = 3'd0;
  localparam logic [2:0] ST_TUNL  = 3'd1;
  localparam logic [2:0] ST_DEV   = 3'd2;
  localparam logic [2:0] ST_PROD  = 3'd3;
  localparam logic [2:0] ST_RMA   = 3'd4;
  localparam logic [2:0] ST_SCRAP = 3'd5;

  localparam logic [1:0] RC_OK  = 2'd0;
  localparam logic [1:0] RC_ILL = 2'd1;
  localparam logic [1:0] RC_TOK = 2'd2;
  localparam logic [1:0] RC_PRE = 2'd3;

  logic [2:0] stage_q, stage_d;
  logic       rv_q;
  logic [1:0] rc_q, rc_d;
  logic       done_q;
  logic       hop_legal;

  always_comb begin
    hop_legal = 1'b0;
    case (stage_q)
      ST_RAW:                 hop_legal = (req_target_i == ST_TUNL);
      ST_TUNL:                hop_legal = (req_target_i == ST_DEV) ||
                                          (req_target_i == ST_PROD) ||
                                          (req_target_i == ST_RMA);
      ST_DEV, ST_PROD, ST_RMA: hop_legal = (req_target_i == ST_SCRAP);
      default:                hop_legal = 1'b0;
    endcase
  end

  wire token_ok = (req_token_i == UNLOCK_TOKEN);

  always_comb begin
    stage_d = stage_q;
    rc_d    = RC_OK;
    if (esc_scrap_i) begin
      stage_d = ST_SCRAP;
      rc_d    = RC_PRE;
    end else if (!hop_legal) begin
      rc_d = RC_ILL;
    end else if (!token_ok) begin
      rc_d = RC_TOK;
    end else if (req_valid_i) begin
      stage_d = req_target_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= ST_RAW;
      rv_q    <= 1'b0;
      rc_q    <= RC_OK;
      done_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rv_q    <= req_valid_i;
      rc_q    <= req_valid_i ? rc_d : RC_OK;
      done_q  <= rv_q && (rc_q == RC_OK);
    end
  end

  assign stage_o      = stage_q;
  assign resp_valid_o = rv_q;
  assign resp_code_o  = rc_q;
  assign hop_done_o   = done_q;

  // R7
  esc_forces_scrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_scrap_i |=> (stage_q == ST_SCRAP));

  // R5
  scrap_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_SCRAP) |=> (stage_q == ST_SCRAP));

  // R4 R6
  reject_holds_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && (rc_q == RC_ILL || rc_q == RC_TOK)) |-> (stage_q == $past(stage_q)));

  // R9
  done_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && rc_q == RC_OK) |=> done_q);

  // R9
  done_only_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(rv_q && rc_q == RC_OK));

  // R10
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rv_q);

  // R8
  preempt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && esc_scrap_i) |=> (rc_q == RC_PRE && stage_q == ST_SCRAP));

endmodule

// File: tb/sim_lifecycle_ctrl.sv
module sim_lifecycle_ctrl;
  localparam int          TW  = 32;
  localparam logic [31:0] TOK = 32'h1234_ABCD;
  localparam logic [31:0] BAD = 32'h1234_ABCC;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_target = '0;
  logic [TW-1:0] req_token = '0;
  logic          esc = 1'b0;
  logic [2:0]    stage;
  logic          rv;
  logic [1:0]    rc;
  logic          done;

  lifecycle_ctrl #(.TOKEN_W(TW), .UNLOCK_TOKEN(TOK)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_target_i(req_target),
    .req_token_i(req_token), .esc_scrap_i(esc), .stage_o(stage),
    .resp_valid_o(rv), .resp_code_o(rc), .hop_done_o(done));

  int checks = 0;
  int errors = 0;

  int m_stage = 0, m_code = 0;
  bit m_rv = 0, m_done = 0;
  string cur_tag = "R1";

  function automatic bit allowed(int f, int t);
    if (f == 0) return t == 1;
    if (f == 1) return t >= 2 && t <= 4;
    if (f >= 2 && f <= 4) return t == 5;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_rv = 0; m_code = 0; m_done = 0;
    end else begin
      m_done = m_rv && (m_code == 0);
      m_rv   = req_valid;
      m_code = 0;
      if (esc) begin
        m_stage = 5;
        if (req_valid) m_code = 3;
      end else if (req_valid) begin
        if (!allowed(m_stage, int'(req_target))) m_code = 1;
        else if (req_token != TOK) m_code = 2;
        else m_stage = int'(req_target);
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("stage", int'(stage), m_stage);
    cmp("resp_valid", int'(rv), int'(m_rv));
    if (m_rv) cmp("resp_code", int'(rc), m_code);
    cmp("hop_done", int'(done), int'(m_done));
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(string tag, int tgt, logic [31:0] tk, bit e);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1'b1; req_target = tgt[2:0]; req_token = tk; esc = e;
    @(negedge clk);
    req_valid = 1'b0; esc = 1'b0;
    idle(2);
  endtask

  task automatic escalate(string tag);
    @(negedge clk);
    cur_tag = tag;
    esc = 1'b1;
    @(negedge clk);
    esc = 1'b0;
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cur_tag = "R1";
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    request("R4", 2, TOK, 0);
    request("R4", 0, TOK, 0);
    request("R6", 1, BAD, 0);
    request("R6", 2, BAD, 0);
    request("R2", 1, TOK, 0);
    request("R4", 1, TOK, 0);
    request("R4", 7, TOK, 0);
    request("R4", 5, TOK, 0);
    request("R3", 3, TOK, 0);
    request("R4", 2, TOK, 0);
    request("R6", 5, BAD, 0);
    request("R3", 5, TOK, 0);
    request("R5", 0, TOK, 0);
    request("R5", 1, TOK, 0);
    request("R5", 5, TOK, 0);
    request("R5", 6, BAD, 0);

    for (int t = 2; t <= 4; t++) begin
      do_reset();
      request("R2", 1, TOK, 0);
      request("R3", t, TOK, 0);
      request("R3", 5, TOK, 0);
    end

    do_reset();
    escalate("R7");
    escalate("R7");
    do_reset();
    request("R2", 1, TOK, 0);
    request("R8", 2, TOK, 1);
    request("R5", 3, TOK, 0);
    do_reset();
    request("R2", 1, TOK, 0);
    request("R3", 4, TOK, 0);
    escalate("R7");
    do_reset();
    request("R8", 1, TOK, 1);

    do_reset();
    @(negedge clk);
    cur_tag = "R9";
    req_valid = 1'b1; req_target = 3'd1; req_token = TOK;
    @(negedge clk);
    req_valid = 1'b0; esc = 1'b1;
    @(negedge clk);
    esc = 1'b0;
    idle(3);

    do_reset();
    cur_tag = "R10";
    @(negedge clk);
    req_valid = 1'b1; req_target = 3'd1; req_token = TOK;
    @(negedge clk);
    req_target = 3'd2;
    @(negedge clk);
    req_target = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule